// File: doc/BRIEF.md
# Double-Buffered Oversampling Serial Port

This block joins a byte-wide processor side to one serial receive wire and one serial transmit wire using start-stop framing. A line at rest sits at 1. A character opens with a 0 start bit, carries 8 data bits with the least significant bit first, and closes with one or two stop bits at 1.

Timing comes from a one-cycle enable, `tick_16x`, that pulses sixteen times per bit period. The receiver synchronises the incoming wire and watches for a falling edge. It confirms the start bit half a bit later, then samples once per bit near the bit centre. The result sits in a shift register until the stop bit is sampled, and then moves as a whole byte into a holding register. Transmission runs the same way in reverse. A written byte waits in a holding register until the output shifter is free, then moves into the shifter, which frees the holding register for the next byte.

Because the shift registers and holding registers are separate, characters can stream back-to-back in both directions. Both byte paths use valid/ready handshakes. On the receive side, `rx_valid` with `rx_data` stays asserted and unchanged until the cycle in which `rx_ready` is also high, and that cycle pops the byte. The serial line cannot be stalled, so a byte that completes while the previous one is still unread is dropped and recorded as an overrun. On the transmit side, `tx_ready` is high exactly when the holding register is empty, and a byte is taken on any rising edge where `tx_valid` and `tx_ready` are both high.

Top module: `serial_dbuf_port`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_ready` is 1, and `rx_valid`, `rx_frame_err` and `rx_overrun` are 0.
- R2: A receive start is accepted only if the synchronised line, low at the tick where the falling edge is seen, is still low 8 ticks later. A low pulse that ends before then is discarded and delivers no byte.
- R3: After the start is confirmed, the receiver samples the line every 16 ticks. The first 8 samples are data bits, least significant first, so `rx_data[0]` is the first bit on the wire. The byte reaches `rx_data` with `rx_valid` = 1 when the first stop bit is sampled.
- R4: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` stays unchanged. A cycle with both high pops the byte and clears `rx_valid`, `rx_frame_err` and `rx_overrun`.
- R5: A character that follows the previous one with no idle gap is received correctly, as long as the previous byte is popped before the new stop bit is sampled.
- R6: If a byte completes while `rx_valid` is 1 and no pop happens in that cycle, the new byte is discarded, `rx_data` keeps the old byte, and `rx_overrun` becomes 1.
- R7: Only the first stop bit is checked. If that sample is 0, the byte is still delivered, with `rx_frame_err` = 1.
- R8: A transmitted character is a 0 start bit, then 8 data bits least significant first, then stop bits at 1. Each bit lasts 16 ticks. `tx_line` is 1 whenever the shifter is idle.
- R9: An accepted write drops `tx_ready` at the next edge. If the shifter is idle, the byte moves into it at the following edge, which raises `tx_ready` again while the start bit is already on `tx_line`.
- R10: `cfg_two_stop`, sampled when a byte moves into the shifter, selects 32 ticks of stop time (1) or 16 ticks (0). A byte already waiting starts its start bit as soon as that stop time ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16x | input | 1 | One-cycle enable, 16 per bit period |
| cfg_two_stop | input | 1 | 1 = transmit two stop bits, 0 = one |
| rx_line | input | 1 | Serial receive wire, idles at 1 |
| tx_line | output | 1 | Serial transmit wire, idles at 1 |
| tx_valid | input | 1 | Write byte offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 8 | Byte to transmit |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Processor takes the received byte |
| rx_data | output | 8 | Received byte |
| rx_frame_err | output | 1 | First stop bit of the held byte was 0 |
| rx_overrun | output | 1 | A byte was lost while the holding register was full |

## Verification
The bench sends a low pulse shorter than half a bit. A receiver that skips the mid-start check would treat it as a start bit and later deliver a false byte. It streams two receive characters with no gap and pops the first while the second is still arriving. A design without a separate shift register would lose or corrupt the second byte. It lets a byte arrive over an unread one, which shows whether the old data survives and the overrun flag rises. It also sends a character with a zero stop bit, where a careless design would drop the byte or leave the error flag clear. On the transmit side, the bench measures the idle time between two queued characters under both stop settings. A wrong stop count shows up there as a gap that is too short or too long. It also checks that `tx_ready` comes back while the first character is still going out, which a design without a separate holding register would not do.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_START = 2'd1,
    LN_DATA  = 2'd2,
    LN_STOP  = 2'd3
  } line_state_e;
endpackage

// File: rtl/sio_rx_deframer.sv
module sio_rx_deframer
  import sio_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_in,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 frame_bad_o,
  output logic                 busy_o
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DATA_BITS + 1);
  localparam int HALF = OSR / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   prev_q;
  line_state_e            st_q;
  logic [CW-1:0]          cnt_q;
  logic [BW-1:0]          bitn_q;
  logic [DATA_BITS-1:0]   shreg_q;

  // metastability guard on the asynchronous wire
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end
  assign line_s = sync_q[SYNC_STAGES-1];

  // line level seen at the previous tick, for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n)    prev_q <= 1'b1;
    else if (tick) prev_q <= line_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= LN_IDLE;
      cnt_q       <= '0;
      bitn_q      <= '0;
      shreg_q     <= '0;
      done_o      <= 1'b0;
      frame_bad_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick) begin
        unique case (st_q)
          LN_IDLE: begin
            if (prev_q && !line_s) begin
              cnt_q <= '0;
              st_q  <= LN_START;
            end
          end
          LN_START: begin
            if (cnt_q == CW'(HALF - 1)) begin
              cnt_q <= '0;
              if (!line_s) begin
                bitn_q <= '0;
                st_q   <= LN_DATA;
              end else begin
                st_q <= LN_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          LN_DATA: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q   <= '0;
              shreg_q <= {line_s, shreg_q[DATA_BITS-1:1]};
              bitn_q  <= bitn_q + 1'b1;
              if (bitn_q == BW'(DATA_BITS - 1)) st_q <= LN_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          LN_STOP: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q       <= '0;
              done_o      <= 1'b1;
              frame_bad_o <= !line_s;
              st_q        <= LN_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= LN_IDLE;
        endcase
      end
    end
  end

  assign byte_o = shreg_q;
  assign busy_o = (st_q != LN_IDLE);
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] byte_i,
  input  logic                 frame_bad_i,
  input  logic                 pop_ready_i,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 frame_err_o,
  output logic                 overrun_o
);
  logic pop;
  assign pop = valid_o && pop_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o     <= 1'b0;
      data_o      <= '0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      if (pop) begin
        valid_o     <= 1'b0;
        frame_err_o <= 1'b0;
        overrun_o   <= 1'b0;
      end
      if (done_i) begin
        if (valid_o && !pop) begin
          overrun_o <= 1'b1;
        end else begin
          data_o      <= byte_i;
          valid_o     <= 1'b1;
          frame_err_o <= frame_bad_i;
        end
      end
    end
  end
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid_i,
  input  logic [DATA_BITS-1:0] wr_data_i,
  input  logic                 take_i,
  output logic                 full_o,
  output logic [DATA_BITS-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else begin
      if (take_i) full_o <= 1'b0;
      if (wr_valid_i && !full_o) begin
        full_o <= 1'b1;
        data_o <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/sio_tx_serializer.sv
module sio_tx_serializer
  import sio_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 two_stop_i,
  input  logic                 hold_full_i,
  input  logic [DATA_BITS-1:0] hold_data_i,
  output logic                 take_o,
  output logic                 line_o,
  output logic                 busy_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_BITS + 1);

  line_state_e          st_q;
  logic [CW-1:0]        cnt_q;
  logic [BW-1:0]        bitn_q;
  logic [DATA_BITS-1:0] sh_q;
  logic                 stop2_q;
  logic                 stopn_q;
  logic                 bit_end;

  assign take_o  = (st_q == LN_IDLE) && hold_full_i;
  assign bit_end = tick && (cnt_q == CW'(OSR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= LN_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      stop2_q <= 1'b0;
      stopn_q <= 1'b0;
      line_o  <= 1'b1;
    end else begin
      if (tick && st_q != LN_IDLE) cnt_q <= cnt_q + 1'b1;
      unique case (st_q)
        LN_IDLE: begin
          line_o <= 1'b1;
          if (hold_full_i) begin
            sh_q    <= hold_data_i;
            stop2_q <= two_stop_i;
            cnt_q   <= '0;
            line_o  <= 1'b0;
            st_q    <= LN_START;
          end
        end
        LN_START: begin
          if (bit_end) begin
            cnt_q  <= '0;
            bitn_q <= '0;
            line_o <= sh_q[0];
            st_q   <= LN_DATA;
          end
        end
        LN_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (bitn_q == BW'(DATA_BITS - 1)) begin
              line_o  <= 1'b1;
              stopn_q <= 1'b0;
              st_q    <= LN_STOP;
            end else begin
              line_o <= sh_q[1];
              sh_q   <= sh_q >> 1;
              bitn_q <= bitn_q + 1'b1;
            end
          end
        end
        LN_STOP: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (stop2_q && !stopn_q) stopn_q <= 1'b1;
            else                     st_q    <= LN_IDLE;
          end
        end
        default: st_q <= LN_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != LN_IDLE);
endmodule

// File: rtl/serial_dbuf_port.sv
module serial_dbuf_port #(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_16x,
  input  logic                 cfg_two_stop,
  input  logic                 rx_line,
  output logic                 tx_line,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_frame_err,
  output logic                 rx_overrun
);
  logic                 rx_done;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 rx_bad;
  logic                 rx_busy;
  logic                 tx_full;
  logic [DATA_BITS-1:0] tx_hold;
  logic                 tx_take;
  logic                 tx_busy;

  sio_rx_deframer #(
    .DATA_BITS(DATA_BITS), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)
  ) u_rx_deframer (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .line_in(rx_line),
    .done_o(rx_done), .byte_o(rx_byte), .frame_bad_o(rx_bad), .busy_o(rx_busy)
  );

  sio_rx_hold #(.DATA_BITS(DATA_BITS)) u_rx_hold (
    .clk(clk), .rst_n(rst_n), .done_i(rx_done), .byte_i(rx_byte),
    .frame_bad_i(rx_bad), .pop_ready_i(rx_ready), .valid_o(rx_valid),
    .data_o(rx_data), .frame_err_o(rx_frame_err), .overrun_o(rx_overrun)
  );

  sio_tx_hold #(.DATA_BITS(DATA_BITS)) u_tx_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(tx_valid), .wr_data_i(tx_data),
    .take_i(tx_take), .full_o(tx_full), .data_o(tx_hold)
  );

  sio_tx_serializer #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_tx_serializer (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .two_stop_i(cfg_two_stop),
    .hold_full_i(tx_full), .hold_data_i(tx_hold), .take_o(tx_take),
    .line_o(tx_line), .busy_o(tx_busy)
  );

  assign tx_ready = !tx_full;
endmodule

// File: rtl/serial_dbuf_port_checker.sv
module serial_dbuf_port_checker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_line,
  input logic                 tx_busy,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_overrun
);
  assert_tx_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  assert_rx_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_rx_pop_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(rx_ready));

  assert_overrun_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_valid);

  assert_tx_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind serial_dbuf_port serial_dbuf_port_checker #(.DATA_BITS(DATA_BITS)) u_checker (
  .clk(clk), .rst_n(rst_n), .tx_line(tx_line), .tx_busy(tx_busy),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .rx_overrun(rx_overrun)
);

// File: tb/serial_dbuf_port_bench.sv
`timescale 1ns/1ps
module serial_dbuf_port_bench;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16x = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       rx_line = 1'b1;
  logic       tx_line;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_frame_err;
  logic       rx_overrun;

  int  n_checks = 0;
  int  n_fails  = 0;
  int  div_cnt  = 0;
  time fall_t;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    div_cnt  <= (div_cnt == TDIV - 1) ? 0 : div_cnt + 1;
    tick_16x <= (div_cnt == TDIV - 1);
  end

  serial_dbuf_port u_serial_dbuf_port (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .cfg_two_stop(cfg_two_stop),
    .rx_line(rx_line), .tx_line(tx_line), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clocks);
    @(negedge clk);
    rx_line = v;
    repeat (clocks - 1) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] b, input logic stop_v);
    hold_line(1'b0, BITC);
    for (int i = 0; i < 8; i++) hold_line(b[i], BITC);
    hold_line(stop_v, BITC);
    if (!stop_v) hold_line(1'b1, BITC);
  endtask

  task automatic pop_byte();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic decode_tx(output logic [7:0] b);
    @(negedge clk);
    while (tx_line) @(negedge clk);
    fall_t = $time;
    repeat (BITC / 2) @(negedge clk);
    chk("R8 start bit low", tx_line, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      b[i] = tx_line;
    end
    repeat (BITC) @(negedge clk);
    chk("R8 stop bit high", tx_line, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 tx_line idle", tx_line, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rx_frame_err", rx_frame_err, 0);
    chk("R1 rx_overrun", rx_overrun, 0);
  endtask

  task automatic t_rx_single();
    send_char(8'hA5, 1'b1);
    @(negedge clk);
    chk("R3 rx_valid after char", rx_valid, 1);
    chk("R3 rx_data LSB first", rx_data, 8'hA5);
    chk("R7 no frame error", rx_frame_err, 0);
    repeat (200) @(negedge clk);
    chk("R4 valid held without ready", rx_valid, 1);
    chk("R4 data held without ready", rx_data, 8'hA5);
    pop_byte();
    chk("R4 valid cleared by pop", rx_valid, 0);
  endtask

  task automatic t_rx_stream();
    send_char(8'h3C, 1'b1);
    fork
      send_char(8'hC3, 1'b1);
      begin
        repeat (100) @(negedge clk);
        chk("R5 first byte while next arrives", rx_data, 8'h3C);
        pop_byte();
      end
    join
    @(negedge clk);
    chk("R5 second byte valid", rx_valid, 1);
    chk("R5 second byte data", rx_data, 8'hC3);
    chk("R5 no overrun", rx_overrun, 0);
    pop_byte();
  endtask

  task automatic t_rx_overrun();
    send_char(8'h11, 1'b1);
    send_char(8'h22, 1'b1);
    @(negedge clk);
    chk("R6 overrun raised", rx_overrun, 1);
    chk("R6 old byte kept", rx_data, 8'h11);
    pop_byte();
    chk("R6 overrun cleared by pop", rx_overrun, 0);
    chk("R6 valid cleared by pop", rx_valid, 0);
  endtask

  task automatic t_rx_frame();
    send_char(8'h5A, 1'b0);
    @(negedge clk);
    chk("R7 byte delivered on bad stop", rx_valid, 1);
    chk("R7 byte value on bad stop", rx_data, 8'h5A);
    chk("R7 frame error set", rx_frame_err, 1);
    pop_byte();
    chk("R7 frame error cleared by pop", rx_frame_err, 0);
  endtask

  task automatic t_rx_glitch();
    hold_line(1'b0, 3 * TDIV);
    hold_line(1'b1, 12 * BITC);
    chk("R2 short low pulse ignored", rx_valid, 0);
    send_char(8'h81, 1'b1);
    @(negedge clk);
    chk("R2 receiver recovers after glitch", rx_data, 8'h81);
    pop_byte();
  endtask

  task automatic t_tx_single();
    logic [7:0] got;
    cfg_two_stop = 1'b0;
    fork
      begin
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = 8'h96;
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R9 ready drops after accept", tx_ready, 0);
        @(negedge clk);
        chk("R9 ready back once moved to shifter", tx_ready, 1);
        chk("R9 start bit already driven", tx_line, 0);
      end
      decode_tx(got);
    join
    chk("R8 transmitted byte", got, 8'h96);
    repeat (2 * BITC) @(negedge clk);
  endtask

  task automatic t_tx_pair(input logic two);
    logic [7:0] g1, g2;
    time        t_stop;
    int         gap;
    cfg_two_stop = two;
    fork
      begin
        write_byte(8'hA1);
        write_byte(8'h5E);
        @(negedge clk);
        chk("R9 ready low while second byte waits", tx_ready, 0);
      end
      decode_tx(g1);
    join
    t_stop = $time;
    decode_tx(g2);
    gap = int'((fall_t - t_stop) / 4);
    chk("R8 first queued byte", g1, 8'hA1);
    chk("R8 second queued byte", g2, 8'h5E);
    if (two) chk("R10 two stop gap", int'(gap > 88 && gap < 104), 1);
    else     chk("R10 one stop gap", int'(gap > 24 && gap < 40), 1);
    repeat (3 * BITC) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    repeat (BITC) @(negedge clk);
    t_rx_single();
    t_rx_stream();
    t_rx_overrun();
    t_rx_frame();
    t_rx_glitch();
    t_tx_single();
    t_tx_pair(1'b0);
    t_tx_pair(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule